// File: doc/BRIEF.md
# Motion Sensor Burst Report Reader

This block fetches one motion report from an optical motion sensor over a four-wire serial link and turns it into signed movement values and two status flags. A single-cycle pulse on `start_i` launches a fetch. The block keeps track of whether the sensor is already in burst mode. If it is not, the block first sends a two-byte enable write, releases chip select for a settling gap, and records the mode as active. It then sends the burst address and waits a fixed number of clock cycles. After that it clocks in six report bytes while chip select stays low.

The six bytes arrive as status, a discarded byte, X low, X high, Y low and Y high. Each axis is built as a 16-bit word from its two bytes and then negated in two's complement. The motion flag and the on-surface flag come from the status byte. If any of the three lowest status bits is set, the block treats burst mode as lost, so the next fetch sends the enable write again. The decoded values sit in registers and change only in the cycle where `valid_o` pulses.

The serial link runs in clock-idle-high mode. The master sets each data bit while the serial clock is low and samples the sensor's bit on the rising edge. `HALF_SCLK` sets the serial clock half period, `WAIT_CYCLES` sets the delay after the address byte, and `GAP_CYCLES` sets how long chip select stays high after the enable write.

Top module: `motion_burst_reader`

## Requirements
- R1: While reset is held and right after it is released, `cs_n_o` is 1, `sclk_o` is 1, `valid_o` is 0 and `dx_o`, `dy_o`, `motion_o`, `on_surface_o` are all 0.
- R2: When burst mode is inactive (always true for the first fetch after reset), a fetch starts with a chip-select frame of exactly two bytes, 0xD0 followed by 0x00. Chip select is then released before the read frame begins.
- R3: When burst mode is active, a fetch sends no enable frame: the only chip-select frame is the read frame.
- R4: The read frame is a single chip-select-low frame of seven bytes. The first byte is the address 0x50 with bit 7 clear. The six data bytes are sent as 0x00. At least `WAIT_CYCLES` clock cycles pass between the last rising serial clock edge of the address and the first rising edge of the data.
- R5: The report bytes are taken as status, discarded, X low, X high, Y low, Y high, in that order. The value of the second byte has no effect on any output.
- R6: `dx_o` equals the 16-bit two's complement negation of {X high, X low}, and `dy_o` equals the negation of {Y high, Y low}. For example, 0x0001 gives 0xFFFF, 0x8000 gives 0x8000 and 0xFF38 gives 0x00C8.
- R7: `motion_o` equals status bit 7. `on_surface_o` is 1 exactly when status bit 3 is 0.
- R8: If any of status bits 2, 1 or 0 is set, burst mode becomes inactive, so the next fetch sends the enable frame again. Otherwise burst mode stays active.
- R9: `valid_o` is high for exactly one cycle per fetch. `dx_o`, `dy_o`, `motion_o` and `on_surface_o` change only in a cycle where `valid_o` is high.
- R10: A `start_i` pulse that arrives while a fetch is in progress is ignored: it produces no second `valid_o` and no extra chip-select frame.
- R11: Whenever `cs_n_o` is high, `sclk_o` is high. The sensor's bit is sampled on the rising serial clock edge. `mosi_o` does not change while the serial clock stays high within a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle request to fetch one report |
| sclk_o | output | 1 | Serial clock, idles high |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the sensor |
| miso_i | input | 1 | Serial data from the sensor |
| valid_o | output | 1 | One-cycle pulse when a new report is decoded |
| dx_o | output | 16 | Negated X movement, two's complement |
| dy_o | output | 16 | Negated Y movement, two's complement |
| motion_o | output | 1 | Motion flag from the status byte |
| on_surface_o | output | 1 | High when the sensor is on a surface |

## Verification
The bench plays the sensor, byte by byte, and checks which frames appear. A reader that forgot the burst state would repeat the enable frame on every fetch, or never send it again after an error. Separate fetches set each of the three error bits one at a time, which catches a decoder that tests only some of them. The deltas include 0x8000, zero, and values whose negation carries across the byte boundary, so a missing carry or swapped bytes gives wrong `dx_o`/`dy_o`. The discarded byte is filled with values unlike the real bytes, so an off-by-one byte index shows up. A start pulse sent during a fetch would show up as a second valid pulse or an extra frame.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EN_ADDR,
        ST_EN_DATA,
        ST_EN_GAP,
        ST_RD_ADDR,
        ST_RD_WAIT,
        ST_RD_BYTE,
        ST_DONE
    } seq_e;

    localparam logic [7:0] BURST_REG  = 8'h50;
    localparam logic [7:0] WRITE_FLAG = 8'h80;
    localparam int         REPORT_LEN = 6;

    typedef struct packed {
        logic [7:0] status;
        logic [7:0] x_lo;
        logic [7:0] x_hi;
        logic [7:0] y_lo;
        logic [7:0] y_hi;
    } report_t;

endpackage

// File: rtl/mbr_spi_byte.sv
module mbr_spi_byte #(
    parameter int HALF_SCLK = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);

    localparam int HW = (HALF_SCLK > 1) ? $clog2(HALF_SCLK) : 1;

    typedef struct packed {
        logic          act;
        logic          sclk;
        logic          done;
        logic [2:0]    bit_idx;
        logic [HW-1:0] div;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (start_i) begin
            sh_d.act     = 1'b1;
            sh_d.sclk    = 1'b0;
            sh_d.bit_idx = 3'd0;
            sh_d.div     = '0;
            sh_d.tx      = tx_i;
        end else if (sh_q.act) begin
            if (sh_q.div == HW'(HALF_SCLK - 1)) begin
                sh_d.div = '0;
                if (!sh_q.sclk) begin
                    sh_d.sclk = 1'b1;
                    sh_d.rx   = {sh_q.rx[6:0], miso_i};
                end else if (sh_q.bit_idx == 3'd7) begin
                    sh_d.act  = 1'b0;
                    sh_d.done = 1'b1;
                end else begin
                    sh_d.bit_idx = sh_q.bit_idx + 3'd1;
                    sh_d.sclk    = 1'b0;
                    sh_d.tx      = {sh_q.tx[6:0], 1'b0};
                end
            end else begin
                sh_d.div = sh_q.div + HW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.sclk <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk_o = sh_q.sclk;
    assign mosi_o = sh_q.tx[7];
    assign done_o = sh_q.done;
    assign rx_o   = sh_q.rx;

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.act && $past(sh_q.act) && sh_q.sclk && $past(sh_q.sclk)) |-> $stable(mosi_o)); // R11
    AST_BYTE_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sclk_o); // R11

endmodule

// File: rtl/mbr_report_decode.sv
module mbr_report_decode
    import mbr_pkg::*;
(
    input  report_t     rep_i,
    output logic [15:0] dx_o,
    output logic [15:0] dy_o,
    output logic        motion_o,
    output logic        on_surface_o,
    output logic        fault_o
);

    logic [15:0] x_raw, y_raw;

    always_comb begin
        x_raw        = {rep_i.x_hi, rep_i.x_lo};
        y_raw        = {rep_i.y_hi, rep_i.y_lo};
        dx_o         = (~x_raw) + 16'd1;
        dy_o         = (~y_raw) + 16'd1;
        motion_o     = rep_i.status[7];
        on_surface_o = ~rep_i.status[3];
        fault_o      = |rep_i.status[2:0];
    end

endmodule

// File: rtl/motion_burst_reader.sv
module motion_burst_reader
    import mbr_pkg::*;
#(
    parameter int HALF_SCLK   = 2,
    parameter int WAIT_CYCLES = 8750,
    parameter int GAP_CYCLES  = 30000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        sclk_o,
    output logic        cs_n_o,
    output logic        mosi_o,
    input  logic        miso_i,
    output logic        valid_o,
    output logic [15:0] dx_o,
    output logic [15:0] dy_o,
    output logic        motion_o,
    output logic        on_surface_o
);

    localparam int CNT_MAX = (WAIT_CYCLES > GAP_CYCLES) ? WAIT_CYCLES : GAP_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_e          st;
        logic          cs_n;
        logic          kick;
        logic [7:0]    tx;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic          burst;
        report_t       rep;
        logic          valid;
        logic [15:0]   dx;
        logic [15:0]   dy;
        logic          motion;
        logic          on_surf;
    } ctl_t;

    ctl_t c_d, c_q;

    logic        byte_done;
    logic [7:0]  byte_rx;
    logic [15:0] dec_dx, dec_dy;
    logic        dec_motion, dec_on_surf, dec_fault;

    mbr_spi_byte #(.HALF_SCLK(HALF_SCLK)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(c_q.kick),
        .tx_i   (c_q.tx),
        .miso_i (miso_i),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .done_o (byte_done),
        .rx_o   (byte_rx)
    );

    mbr_report_decode u_dec (
        .rep_i       (c_q.rep),
        .dx_o        (dec_dx),
        .dy_o        (dec_dy),
        .motion_o    (dec_motion),
        .on_surface_o(dec_on_surf),
        .fault_o     (dec_fault)
    );

    always_comb begin
        c_d       = c_q;
        c_d.kick  = 1'b0;
        c_d.valid = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.cs_n = 1'b0;
                    c_d.kick = 1'b1;
                    if (c_q.burst) begin
                        c_d.st = ST_RD_ADDR;
                        c_d.tx = BURST_REG;
                    end else begin
                        c_d.st = ST_EN_ADDR;
                        c_d.tx = BURST_REG | WRITE_FLAG;
                    end
                end
            end
            ST_EN_ADDR: begin
                if (byte_done) begin
                    c_d.st   = ST_EN_DATA;
                    c_d.kick = 1'b1;
                    c_d.tx   = 8'h00;
                end
            end
            ST_EN_DATA: begin
                if (byte_done) begin
                    c_d.cs_n  = 1'b1;
                    c_d.burst = 1'b1;
                    c_d.cnt   = '0;
                    c_d.st    = ST_EN_GAP;
                end
            end
            ST_EN_GAP: begin
                if (c_q.cnt == CW'(GAP_CYCLES - 1)) begin
                    c_d.cs_n = 1'b0;
                    c_d.st   = ST_RD_ADDR;
                    c_d.kick = 1'b1;
                    c_d.tx   = BURST_REG;
                end else begin
                    c_d.cnt = c_q.cnt + CW'(1);
                end
            end
            ST_RD_ADDR: begin
                if (byte_done) begin
                    c_d.cnt = '0;
                    c_d.st  = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (c_q.cnt == CW'(WAIT_CYCLES - 1)) begin
                    c_d.st   = ST_RD_BYTE;
                    c_d.kick = 1'b1;
                    c_d.tx   = 8'h00;
                    c_d.idx  = 3'd0;
                end else begin
                    c_d.cnt = c_q.cnt + CW'(1);
                end
            end
            ST_RD_BYTE: begin
                if (byte_done) begin
                    case (c_q.idx)
                        3'd0:    c_d.rep.status = byte_rx;
                        3'd2:    c_d.rep.x_lo   = byte_rx;
                        3'd3:    c_d.rep.x_hi   = byte_rx;
                        3'd4:    c_d.rep.y_lo   = byte_rx;
                        3'd5:    c_d.rep.y_hi   = byte_rx;
                        default: ;
                    endcase
                    if (c_q.idx == 3'(REPORT_LEN - 1)) begin
                        c_d.st = ST_DONE;
                    end else begin
                        c_d.idx  = c_q.idx + 3'd1;
                        c_d.kick = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                c_d.cs_n    = 1'b1;
                c_d.st      = ST_IDLE;
                c_d.valid   = 1'b1;
                c_d.dx      = dec_dx;
                c_d.dy      = dec_dy;
                c_d.motion  = dec_motion;
                c_d.on_surf = dec_on_surf;
                c_d.burst   = c_q.burst & ~dec_fault;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.cs_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cs_n_o       = c_q.cs_n;
    assign valid_o      = c_q.valid;
    assign dx_o         = c_q.dx;
    assign dy_o         = c_q.dy;
    assign motion_o     = c_q.motion;
    assign on_surface_o = c_q.on_surf;

    AST_IDLE_CLOCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o); // R11
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9
    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable({dx_o, dy_o, motion_o, on_surface_o})); // R9
    AST_ENABLE_ONLY_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_EN_ADDR) |-> !c_q.burst); // R3
    AST_FAULT_DROPS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_DONE && (|c_q.rep.status[2:0])) |=> !c_q.burst); // R8
    AST_CS_LOW_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RD_BYTE || c_q.st == ST_RD_WAIT) |-> !cs_n_o); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RD_WAIT && start_i) |=> (c_q.st == ST_RD_WAIT || c_q.st == ST_RD_BYTE)); // R10

endmodule

// File: tb/sim_motion_burst_reader.sv
`timescale 1ns/1ps
module sim_motion_burst_reader;

    localparam int HALF = 2;
    localparam int WAIT = 40;
    localparam int GAP  = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sclk, cs_n, mosi, miso;
    logic        valid;
    logic [15:0] dx, dy;
    logic        motion, on_surf;

    always #2 clk = ~clk;

    motion_burst_reader #(
        .HALF_SCLK  (HALF),
        .WAIT_CYCLES(WAIT),
        .GAP_CYCLES (GAP)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .sclk_o      (sclk),
        .cs_n_o      (cs_n),
        .mosi_o      (mosi),
        .miso_i      (miso),
        .valid_o     (valid),
        .dx_o        (dx),
        .dy_o        (dy),
        .motion_o    (motion),
        .on_surface_o(on_surf)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural sensor model
    logic [7:0] rep [6];
    int         bitcnt = 0;
    int         bytecnt = 0;
    logic [7:0] shin = 8'h00;
    logic [7:0] cur_addr = 8'h00;
    int         cur_len = 0;
    int         txn_len[$];
    logic [7:0] txn_b[$];
    longint     cyc = 0;
    longint     last_rise = 0;
    logic       prev_cs = 1'b1;
    logic       prev_sclk = 1'b1;
    logic       prev_valid = 1'b0;
    logic [33:0] prev_out = '0;
    int         nvalid = 0;

    always_comb begin
        miso = 1'b0;
        if (!cs_n && bytecnt >= 1 && bytecnt <= 6 && cur_addr == 8'h50)
            miso = rep[bytecnt - 1][3'(7 - bitcnt)];
    end

    always @(negedge clk) begin
        logic [7:0] nb;
        cyc++;
        if (rst_n) begin
            if (cs_n && !sclk) chk(1'b0, "R11 clock low while deselected", 32'(sclk), 32'h1);
            if (!cs_n && prev_cs) begin
                bitcnt  = 0;
                bytecnt = 0;
                cur_len = 0;
            end
            if (!cs_n && sclk && !prev_sclk) begin
                if (bytecnt == 1 && bitcnt == 0 && cur_addr == 8'h50)
                    chk((cyc - last_rise) >= WAIT, "R4 address-to-data delay",
                        32'(cyc - last_rise), 32'(WAIT));
                last_rise = cyc;
                nb   = {shin[6:0], mosi};
                shin = nb;
                bitcnt++;
                if (bitcnt == 8) begin
                    if (bytecnt == 0) cur_addr = nb;
                    txn_b.push_back(nb);
                    cur_len++;
                    bytecnt++;
                    bitcnt = 0;
                end
            end
            if (cs_n && !prev_cs) txn_len.push_back(cur_len);
            if (valid) nvalid++;
            if (valid && prev_valid) chk(1'b0, "R9 valid longer than one cycle", 32'h2, 32'h1);
            if (!valid && {dx, dy, motion, on_surf} != prev_out)
                chk(1'b0, "R9 outputs moved without valid", 32'({dx, dy}), 32'(prev_out[33:2]));
        end
        prev_cs    = cs_n;
        prev_sclk  = sclk;
        prev_valid = valid;
        prev_out   = {dx, dy, motion, on_surf};
    end

    bit burst_m = 1'b0;

    task automatic do_read(input logic [7:0] st, input logic [7:0] ob,
                           input logic [7:0] xl, input logic [7:0] xh,
                           input logic [7:0] yl, input logic [7:0] yh,
                           input bit poke, input string tag);
        bit          exp_en;
        int          to;
        logic [15:0] ex, ey;
        int          base;
        exp_en = !burst_m;
        rep[0] = st; rep[1] = ob; rep[2] = xl; rep[3] = xh; rep[4] = yl; rep[5] = yh;
        txn_len.delete();
        txn_b.delete();
        nvalid = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        to = 0;
        while (!valid && to < 5000) begin
            @(negedge clk);
            to++;
        end
        chk(valid, {tag, " R9 valid reached"}, 32'(valid), 32'h1);
        ex = 16'h0000 - {xh, xl};
        ey = 16'h0000 - {yh, yl};
        chk(dx == ex, {tag, " R6 dx"}, 32'(dx), 32'(ex));
        chk(dy == ey, {tag, " R6 dy"}, 32'(dy), 32'(ey));
        chk(motion == st[7], {tag, " R7 motion"}, 32'(motion), 32'(st[7]));
        chk(on_surf == !st[3], {tag, " R7 on_surface"}, 32'(on_surf), 32'(!st[3]));
        repeat (60) @(negedge clk);
        chk(nvalid == 1, {tag, " R10 valid count"}, 32'(nvalid), 32'h1);
        chk(cs_n == 1'b1, {tag, " R10 no new frame"}, 32'(cs_n), 32'h1);
        chk(txn_len.size() == (exp_en ? 2 : 1), {tag, " R2 R3 frame count"},
            32'(txn_len.size()), exp_en ? 32'h2 : 32'h1);
        base = 0;
        if (exp_en && txn_len.size() >= 1 && txn_b.size() >= 2) begin
            chk(txn_len[0] == 2, {tag, " R2 enable length"}, 32'(txn_len[0]), 32'h2);
            chk(txn_b[0] == 8'hD0, {tag, " R2 enable address"}, 32'(txn_b[0]), 32'hD0);
            chk(txn_b[1] == 8'h00, {tag, " R2 enable data"}, 32'(txn_b[1]), 32'h00);
            base = 2;
        end
        if (txn_len.size() == (exp_en ? 2 : 1) && txn_b.size() == base + 7) begin
            chk(txn_len[txn_len.size() - 1] == 7, {tag, " R4 read length"},
                32'(txn_len[txn_len.size() - 1]), 32'h7);
            chk(txn_b[base] == 8'h50, {tag, " R4 read address"}, 32'(txn_b[base]), 32'h50);
            for (int i = 1; i < 7; i++)
                chk(txn_b[base + i] == 8'h00, {tag, " R4 dummy byte"}, 32'(txn_b[base + i]), 32'h0);
        end else begin
            chk(1'b0, {tag, " R4 read frame bytes"}, 32'(txn_b.size()), 32'(base + 7));
        end
        burst_m = (st[2:0] == 3'b000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 link idle in reset", 32'({cs_n, sclk}), 32'h3);
        chk(valid == 1'b0 && dx == 16'h0 && dy == 16'h0 && motion == 1'b0 && on_surf == 1'b0,
            "R1 outputs clear in reset", 32'({valid, dx}), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1 && valid == 1'b0, "R1 idle after reset",
            32'({cs_n, sclk, valid}), 32'h6);
        // R2 first fetch enables; R6 carry and R7 flags; R5 odd discarded byte
        do_read(8'h80, 8'h5A, 8'h01, 8'h00, 8'h38, 8'hFF, 1'b0, "A");
        // R3 no enable; R5 discarded byte all ones; 0x8000 and zero
        do_read(8'h08, 8'hFF, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0, "B");
        // R8 bit0 fault
        do_read(8'h81, 8'h00, 8'h34, 8'h12, 8'hFF, 8'h00, 1'b0, "C");
        // R8 re-enable after fault; R10 start during fetch
        do_read(8'h00, 8'h81, 8'hCD, 8'hAB, 8'h02, 8'h40, 1'b1, "D");
        // R8 bit2 fault then bit1 fault
        do_read(8'h84, 8'h07, 8'h10, 8'h00, 8'h00, 8'h01, 1'b0, "E");
        do_read(8'h8A, 8'h3C, 8'hFF, 8'hFF, 8'h80, 8'h00, 1'b0, "F");
        do_read(8'h08, 8'hC3, 8'h00, 8'h7F, 8'h01, 8'h80, 1'b1, "G");
        do_read(8'h80, 8'h99, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0, "H");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "watchdog R9", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule